// File: doc/BRIEF.md
# Configurable 8-bit Synchronous Serial Port

This block moves one byte at a time over a three-wire clocked serial link: a shift clock, a serial data output and a serial data input. A host writes the byte to send and raises `start` for one cycle. The port shifts the byte out while it shifts a byte in. When the eighth bit has been captured, the port presents the received byte and raises a one-cycle completion pulse. The host can choose the bit order (most significant or least significant bit first). It can also choose receive-only operation, in which the data output stays idle.

The shift clock comes from one of two places. It can be generated inside the port, from one of three prescaler ratios of the system clock or from an overflow strobe of a neighbouring timer/counter. It can also be supplied from outside, in which case the port follows the edges of the external line after resynchronising it. The clock line idles high. Input data is captured on rising edges of the shift clock, and output data is launched on falling edges. The configuration is captured at `start` and holds for the whole transfer.

Top module: `ssp8_port`

## Requirements
- R1: After reset, `sck_o` and `so` are high, `busy` and `done` are low and `rx_byte` is zero.
- R2: With the internal clock, a transfer produces exactly 8 low-then-high pulses on `sck_o`, and the line is high again when `busy` drops.
- R3: With `cfg_msb_first`=1, `so` presents `tx_byte` bit 7 first and bit 0 last. The first bit received on `si` lands in `rx_byte` bit 7.
- R4: With `cfg_msb_first`=0, `so` presents `tx_byte` bit 0 first and bit 7 last. The first bit received lands in `rx_byte` bit 0.
- R5: `si` is captured on rising edges of the shift clock, and `so` changes only at falling edges of the shift clock while a transfer runs.
- R6: With `cfg_rx_only`=1, `so` stays high for the whole transfer while reception works normally.
- R7: With `cfg_ext_clk`=1, the transfer is timed by the edges of `sck_i`, `sck_o` stays high and `sck_oe` stays low.
- R8: After the eighth rising edge, `rx_byte` is updated, `done` is high for exactly one cycle and `busy` is low.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the running transfer or on its data.
- R10: `cfg_clk_src` selects the internal half-period of the shift clock: 0 gives DIV_A cycles (default 2), 1 gives DIV_B cycles (default 4), 2 gives DIV_C cycles (default 16), and 3 gives one half-period for each `tmr_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_byte | input | 8 | Byte to transmit, taken at start |
| cfg_rx_only | input | 1 | 1: receive only, output held high |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_ext_clk | input | 1 | 1: shift clock taken from sck_i |
| cfg_clk_src | input | 2 | Internal clock source select |
| tmr_tick | input | 1 | Overflow strobe from the timer/counter |
| sck_i | input | 1 | External shift clock line |
| si | input | 1 | Serial data input |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for the shift clock line |
| so | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last received byte |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives in the middle of a transfer with different data and a different configuration. The stimulus waits until the third falling edge of the generated clock, then pulses `start` with an inverted byte and the opposite bit order. The bench then checks that the bit stream, the pulse count and the received byte all still match the first request. The external clock case is also hard to reach, because the port sees `sck_i` only through a synchroniser. The bench drives `sck_i` with half-periods of several system cycles. It reads `so` just before each rising edge it drives, so the check does not depend on the synchroniser latency.

// File: rtl/ssp8_pkg.sv
// Shared types for the synchronous serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package ssp8_pkg;
    typedef enum logic [1:0] {
        SRC_DIV_A = 2'd0,
        SRC_DIV_B = 2'd1,
        SRC_DIV_C = 2'd2,
        SRC_TIMER = 2'd3
    } clk_src_e;
endpackage

// File: rtl/ssp8_baud.sv
// Internal shift-clock strobe generator. Each strobe marks one half-period
// of the shift clock. The strobe comes from a prescaler ratio or from the
// timer overflow strobe.
// Assumes: run is held for the whole transfer; the counter restarts when it drops.
module ssp8_baud
    import ssp8_pkg::*;
#(
    parameter int DIV_A = 2,
    parameter int DIV_B = 4,
    parameter int DIV_C = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_src_e src,
    input  logic     tmr_tick,
    output logic     strobe
);
    localparam int MAXD = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                          : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
    localparam int CW = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the terminal count for the chosen ratio.
    always_comb begin
        case (src)
            SRC_DIV_A: lim = CW'(DIV_A - 1);
            SRC_DIV_B: lim = CW'(DIV_B - 1);
            default:   lim = CW'(DIV_C - 1);
        endcase
    end

    assign strobe = run && ((src == SRC_TIMER) ? tmr_tick : (cnt == lim));

    // Prescale counter, cleared while idle and on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || strobe) begin
            cnt <= '0;
        end else if (src != SRC_TIMER) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssp8_edge_sync.sv
// Two-stage synchroniser for the external shift clock, followed by an
// edge detector. The line is assumed to idle high.
// Assumes: the pin stays at each level for at least two system cycles.
module ssp8_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, last_q;

    // Resynchronise the pin and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q && !last_q;
    assign fall = !sync_q && last_q;
endmodule

// File: rtl/ssp8_shifter.sv
// Shift register, output bit launcher and bit counter. One register
// holds both the outgoing and the incoming bits. A bit is launched on
// a falling event and a bit is captured on a rising event.
// Assumes: the events are one-cycle strobes and never occur together.
module ssp8_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         msb_first,
    input  logic         rx_only,
    input  logic         fall_ev,
    input  logic         rise_ev,
    input  logic         si,
    output logic         so,
    output logic         last,
    output logic [W-1:0] word
);
    localparam int NW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [NW-1:0] nbits_q;
    logic          so_q;

    // Next contents of the register after one captured bit.
    assign word = msb_first ? {sh_q[W-2:0], si} : {si, sh_q[W-1:1]};
    assign last = rise_ev && (nbits_q == NW'(W - 1));
    assign so   = so_q;

    // Load, launch and capture sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            nbits_q <= '0;
            so_q    <= 1'b1;
        end else if (load) begin
            sh_q    <= load_data;
            nbits_q <= '0;
            so_q    <= 1'b1;
        end else begin
            if (fall_ev) begin
                so_q <= rx_only ? 1'b1 : (msb_first ? sh_q[W-1] : sh_q[0]);
            end
            if (rise_ev) begin
                sh_q    <= word;
                nbits_q <= nbits_q + 1'b1;
            end
            if (last) begin
                so_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssp8_port.sv
// Top of the synchronous serial port. It captures the configuration at
// start, makes the shift-clock events from the internal strobe or the
// synchronised external line, and reports the received byte.
// Assumes: start is a one-cycle pulse; it is ignored while busy.
module ssp8_port
    import ssp8_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_A = 2,
    parameter int DIV_B = 4,
    parameter int DIV_C = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cfg_rx_only,
    input  logic         cfg_msb_first,
    input  logic         cfg_ext_clk,
    input  logic [1:0]   cfg_clk_src,
    input  logic         tmr_tick,
    input  logic         sck_i,
    input  logic         si,
    output logic         sck_o,
    output logic         sck_oe,
    output logic         so,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    logic     busy_q, done_q, sck_q;
    logic     lat_rx_only, lat_msb, lat_ext;
    clk_src_e lat_src;
    logic     start_ok, strobe, x_rise, x_fall;
    logic     fall_ev, rise_ev, last;
    logic [W-1:0] word, rx_q;

    assign start_ok = start && !busy_q;

    // Configuration snapshot taken when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_rx_only <= 1'b0;
            lat_msb     <= 1'b0;
            lat_ext     <= 1'b0;
            lat_src     <= SRC_DIV_A;
        end else if (start_ok) begin
            lat_rx_only <= cfg_rx_only;
            lat_msb     <= cfg_msb_first;
            lat_ext     <= cfg_ext_clk;
            lat_src     <= clk_src_e'(cfg_clk_src);
        end
    end

    ssp8_baud #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) i_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q && !lat_ext),
        .src      (lat_src),
        .tmr_tick (tmr_tick),
        .strobe   (strobe)
    );

    ssp8_edge_sync i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_i),
        .rise  (x_rise),
        .fall  (x_fall)
    );

    // Shift-clock events from whichever source is selected.
    always_comb begin
        if (lat_ext) begin
            fall_ev = busy_q && x_fall;
            rise_ev = busy_q && x_rise;
        end else begin
            fall_ev = busy_q && strobe && sck_q;
            rise_ev = busy_q && strobe && !sck_q;
        end
    end

    ssp8_shifter #(.W(W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .load_data (tx_byte),
        .msb_first (lat_msb),
        .rx_only   (lat_rx_only),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .si        (si),
        .so        (so),
        .last      (last),
        .word      (word)
    );

    // Transfer state, generated clock level and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sck_q  <= 1'b1;
            rx_q   <= '0;
        end else begin
            done_q <= last;
            if (start_ok) begin
                busy_q <= 1'b1;
            end else if (last) begin
                busy_q <= 1'b0;
                rx_q   <= word;
            end
            if (!lat_ext && fall_ev) begin
                sck_q <= 1'b0;
            end else if (!lat_ext && rise_ev) begin
                sck_q <= 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sck_o   = sck_q;
    assign sck_oe  = busy_q && !lat_ext;
    assign rx_byte = rx_q;
endmodule

// File: rtl/ssp8_port_chk.sv
// Property checker for the serial port. It is bound into the top module.
// Assumes: connection to the top module's ports and its configuration snapshot.
module ssp8_port_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sck_o,
    input logic sck_oe,
    input logic so,
    input logic lat_rx_only,
    input logic lat_ext
);
    // R1/R2: the generated clock is high whenever no transfer runs.
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);

    // R8: the completion pulse lasts one cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the port is no longer busy when it reports completion.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: receive-only keeps the data output high.
    p_rxonly_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lat_rx_only) |-> so);

    // R5: while the internal clock runs, so moves only with a falling clock.
    p_so_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !lat_ext && (so != $past(so))) |-> $fell(sck_o));

    // R7: an external clock is never driven by the port.
    p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lat_ext) |-> (!sck_oe && sck_o));
endmodule

bind ssp8_port ssp8_port_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .sck_o       (sck_o),
    .sck_oe      (sck_oe),
    .so          (so),
    .lat_rx_only (lat_rx_only),
    .lat_ext     (lat_ext)
);

// File: tb/test_ssp8_port.sv
// Directed bench for the serial port: one task per scenario.
module test_ssp8_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       cfg_rx_only = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [1:0] cfg_clk_src = 2'd0;
    logic       tmr_tick = 1'b0;
    logic       sck_i = 1'b1;
    logic       si = 1'b1;
    logic       sck_o, sck_oe, so, busy, done;
    logic [7:0] rx_byte;

    int errors = 0;
    int checks = 0;

    // Monitor state, reset at the start of every transfer.
    int         cyc, nfall, nrise, dones, so_low, bad_ext, t_fall, t_rise, tick_per;
    logic       prev_sck, last_so, cur_msb, cur_ext;
    logic [7:0] cur_si, so_bits, rx_seen;

    ssp8_port i_ssp8_port (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .cfg_rx_only(cfg_rx_only), .cfg_msb_first(cfg_msb_first),
        .cfg_ext_clk(cfg_ext_clk), .cfg_clk_src(cfg_clk_src),
        .tmr_tick(tmr_tick), .sck_i(sck_i), .si(si), .sck_o(sck_o),
        .sck_oe(sck_oe), .so(so), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    // Advance one cycle and update the monitors at the falling clock edge.
    task automatic step();
        tmr_tick = (tick_per != 0) && (cyc % tick_per == tick_per - 1);
        @(negedge clk);
        cyc++;
        if (done) begin
            dones++;
            rx_seen = rx_byte;
        end
        if (so !== 1'b1) so_low++;
        if (cur_ext && (sck_o !== 1'b1 || sck_oe !== 1'b0)) bad_ext++;
        if (prev_sck && !sck_o) begin
            si = cur_msb ? cur_si[7 - nfall] : cur_si[nfall];
            if (nfall == 0) t_fall = cyc;
            nfall++;
        end
        if (!prev_sck && sck_o) begin
            if (nrise < 8) so_bits[cur_msb ? 7 - nrise : nrise] = last_so;
            if (nrise == 0) t_rise = cyc;
            nrise++;
        end
        if (!sck_o) last_so = so;
        prev_sck = sck_o;
    endtask

    task automatic begin_xfer(input logic [7:0] tx, input logic [7:0] sib,
                              input logic msb, input logic rxo, input logic ext,
                              input logic [1:0] src, input int tp);
        cyc = 0; nfall = 0; nrise = 0; dones = 0; so_low = 0; bad_ext = 0;
        t_fall = 0; t_rise = 0; tick_per = tp; prev_sck = 1'b1; last_so = 1'b1;
        cur_msb = msb; cur_ext = ext; cur_si = sib; so_bits = 8'h00; rx_seen = 8'h00;
        tx_byte = tx; cfg_msb_first = msb; cfg_rx_only = rxo;
        cfg_ext_clk = ext; cfg_clk_src = src; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic finish_xfer(input string req);
        int guard = 0;
        while (dones == 0 && guard < 3000) begin
            step();
            guard++;
        end
        check(req, "transfer completed", int'(dones != 0), 1);
        repeat (3) step();
    endtask

    task automatic t_reset();
        check("R1", "sck_o", sck_o, 1);
        check("R1", "so", so, 1);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "rx_byte", rx_byte, 0);
    endtask

    task automatic t_msb_fast();
        begin_xfer(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, 2'd0, 0);
        finish_xfer("R8");
        check("R2", "rising edges", nrise, 8);
        check("R2", "sck_o high after", sck_o, 1);
        check("R3", "so order msb", so_bits, 8'hA5);
        check("R3", "rx msb", rx_seen, 8'h3C);
        check("R5", "rx_byte port", rx_byte, 8'h3C);
        check("R8", "done width", dones, 1);
        check("R8", "busy low", busy, 0);
        check("R10", "half period div A", t_rise - t_fall, 2);
    endtask

    task automatic t_lsb_mid();
        begin_xfer(8'h96, 8'hC1, 1'b0, 1'b0, 1'b0, 2'd1, 0);
        finish_xfer("R8");
        check("R4", "so order lsb", so_bits, 8'h96);
        check("R4", "rx lsb", rx_seen, 8'hC1);
        check("R2", "rising edges", nrise, 8);
        check("R10", "half period div B", t_rise - t_fall, 4);
    endtask

    task automatic t_rx_only();
        begin_xfer(8'h00, 8'h5A, 1'b1, 1'b1, 1'b0, 2'd2, 0);
        finish_xfer("R8");
        check("R6", "so low cycles", so_low, 0);
        check("R6", "rx in rx-only", rx_seen, 8'h5A);
        check("R10", "half period div C", t_rise - t_fall, 16);
    endtask

    task automatic t_timer_src();
        begin_xfer(8'h3E, 8'h81, 1'b0, 1'b0, 1'b0, 2'd3, 5);
        finish_xfer("R8");
        tick_per = 0;
        tmr_tick = 1'b0;
        check("R10", "half period timer", t_rise - t_fall, 5);
        check("R10", "so timer", so_bits, 8'h3E);
        check("R10", "rx timer", rx_seen, 8'h81);
    endtask

    task automatic t_ext_clock(input logic msb, input logic [7:0] tx, input logic [7:0] sib);
        logic [7:0] seen = 8'h00;
        begin_xfer(tx, sib, msb, 1'b0, 1'b1, 2'd0, 0);
        repeat (4) step();
        for (int k = 0; k < 8; k++) begin
            sck_i = 1'b0;
            si = msb ? sib[7 - k] : sib[k];
            repeat (6) step();
            seen[msb ? 7 - k : k] = so;
            sck_i = 1'b1;
            repeat (6) step();
        end
        finish_xfer("R7");
        check("R7", "ext so stream", seen, tx);
        check("R7", "ext rx", rx_seen, sib);
        check("R7", "ext sck not driven", bad_ext, 0);
        check("R7", "ext done width", dones, 1);
    endtask

    task automatic t_busy_restart();
        begin_xfer(8'h4D, 8'hE2, 1'b1, 1'b0, 1'b0, 2'd1, 0);
        while (nfall < 3) step();
        tx_byte = 8'hB2; cfg_msb_first = 1'b0; cfg_rx_only = 1'b1; start = 1'b1;
        step();
        start = 1'b0;
        finish_xfer("R9");
        check("R9", "so unchanged by restart", so_bits, 8'h4D);
        check("R9", "rx unchanged by restart", rx_seen, 8'hE2);
        check("R9", "pulse count unchanged", nrise, 8);
        check("R9", "single done", dones, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick_per = 0;
        cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msb_fast();
        t_lsb_mid();
        t_rx_only();
        t_timer_src();
        t_ext_clock(1'b1, 8'hC3, 8'h69);
        t_ext_clock(1'b0, 8'h17, 8'hF0);
        t_busy_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule